// File: doc/BRIEF.md
# Per-Queue Packet Ready Tracker

This block sits beside a multi-queue FIFO and follows packet boundaries without touching the stored data. As each word is written, the writer flags it as the first word of a packet, the last word of a packet, or both. As each word is read, the reader flags whether it is the last word of a packet. For every queue the block keeps a count of complete packets stored there. It presents a packet-ready vector with one bit per queue, and a registered packet-ready bit for the queue currently selected on the read side.

Tracking runs only while both data ports are configured at full width. A partial reset clears the tracking state of a single queue. A start flag that arrives while a packet on that queue is still unfinished sets a sticky per-queue error bit.

Top module: `pkt_ready_tracker`

## Requirements
- R1: While `rstN` is low, `readyVec`, `errVec` and `rdReady` are all zero, and every packet count is zero.
- R2: A write with `wrEn`=1 and `wrEnd`=1 to queue q (a queue is numbered by the binary value of `wrQueue`/`rdQueue`/`prstQueue`) increments q's count, so `readyVec[q]` is 1 after that clock edge.
- R3: A read with `rdEn`=1 and `rdEnd`=1 on queue q decrements q's count. `readyVec[q]` drops to 0 when the count reaches zero. A read flagged as last on a queue whose count is zero leaves the count at zero.
- R4: When a write flagged as last and a read flagged as last target the same queue in the same cycle, that queue's count is unchanged.
- R5: Each queue keeps its own count. A write to one queue and a read from another queue in the same cycle each affect only their own queue.
- R6: `rdReady` after a clock edge equals `readyVec[rdQueue]` as it was just before that edge, so it lags a count change by one cycle.
- R7: A write flagged as start (`wrStart`=1) to a queue whose packet is still open sets `errVec[q]`. The bit then stays set until `rstN` goes low. A word flagged as both start and last does not leave the packet open.
- R8: `prstEn`=1 clears the count and the open-packet state of queue `prstQueue` at the next edge. This takes priority over any write or read to that queue in the same cycle. `errVec` is not cleared.
- R9: While `wrBusWide` or `rdBusWide` is 0, all flags are ignored, `readyVec` is all zero and `rdReady` becomes 0. The counts are retained and show again once both inputs return to 1.
- R10: A count saturates at 2^CNT_W-1. Further writes flagged as last do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| wrBusWide | input | 1 | Write port configured at full width |
| rdBusWide | input | 1 | Read port configured at full width |
| wrEn | input | 1 | A word is written this cycle |
| wrQueue | input | 3 | Queue selected for writing |
| wrStart | input | 1 | Written word is the first of a packet |
| wrEnd | input | 1 | Written word is the last of a packet |
| rdEn | input | 1 | A word is read this cycle |
| rdQueue | input | 3 | Queue selected for reading |
| rdEnd | input | 1 | Read word is the last of a packet |
| prstEn | input | 1 | Partial reset of one queue |
| prstQueue | input | 3 | Queue to partially reset |
| readyVec | output | 8 | Per-queue packet-ready flags |
| rdReady | output | 1 | Registered packet-ready for the read queue |
| errVec | output | 8 | Sticky per-queue start-while-open error |

## Verification
`readyVec` and `errVec` reflect a flag after the same clock edge that captures it. `rdReady` needs one more edge, because it registers `readyVec`. The bench changes inputs on the falling edge and updates its model at the rising edge. At the rising edge it also computes the expected `rdReady` from the counts held before that edge. It compares all three outputs at the next falling edge, so each expected value is checked in the cycle it becomes due.

// File: rtl/pkt_ready_pkg.sv
package pkt_ready_pkg;
  localparam int unsigned PR_QUEUES = 8;
  localparam int unsigned PR_QSEL_W = (PR_QUEUES > 1) ? $clog2(PR_QUEUES) : 1;

  typedef logic [PR_QUEUES-1:0] qMask_t;

  // strobes from control to datapath, one bit per queue
  typedef struct packed {
    logic   active;
    qMask_t incQ;
    qMask_t decQ;
    qMask_t clrQ;
    qMask_t openSetQ;
    qMask_t openClrQ;
    qMask_t errSetQ;
  } prStrobes_t;
endpackage

// File: rtl/pr_ctrl.sv
module pr_ctrl
  import pkt_ready_pkg::*;
(
  input  logic                 wrBusWide,
  input  logic                 rdBusWide,
  input  logic                 wrEn,
  input  logic [PR_QSEL_W-1:0] wrQueue,
  input  logic                 wrStart,
  input  logic                 wrEnd,
  input  logic                 rdEn,
  input  logic [PR_QSEL_W-1:0] rdQueue,
  input  logic                 rdEnd,
  input  logic                 prstEn,
  input  logic [PR_QSEL_W-1:0] prstQueue,
  input  qMask_t               openQ,
  output prStrobes_t           strobes
);
  logic   active;
  qMask_t incQ, decQ, clrQ, openSetQ, openClrQ, errSetQ;

  assign active = wrBusWide & rdBusWide;

  for (genvar q = 0; q < PR_QUEUES; q++) begin : g_queue
    logic wrHit, rdHit, wrClose, rdClose, clrHit;
    assign wrHit   = active & wrEn & (wrQueue == PR_QSEL_W'(q));
    assign rdHit   = active & rdEn & (rdQueue == PR_QSEL_W'(q));
    assign clrHit  = prstEn & (prstQueue == PR_QSEL_W'(q));
    assign wrClose = wrHit & wrEnd;
    assign rdClose = rdHit & rdEnd;

    // simultaneous close on both sides cancels out
    assign incQ[q]     = wrClose & ~rdClose & ~clrHit;
    assign decQ[q]     = rdClose & ~wrClose & ~clrHit;
    assign clrQ[q]     = clrHit;
    assign openSetQ[q] = wrHit & wrStart & ~wrEnd & ~clrHit;
    assign openClrQ[q] = wrClose & ~clrHit;
    assign errSetQ[q]  = wrHit & wrStart & openQ[q] & ~clrHit;
  end

  assign strobes = '{active:   active,
                     incQ:     incQ,
                     decQ:     decQ,
                     clrQ:     clrQ,
                     openSetQ: openSetQ,
                     openClrQ: openClrQ,
                     errSetQ:  errSetQ};
endmodule

// File: rtl/pr_datapath.sv
module pr_datapath
  import pkt_ready_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  prStrobes_t           strobes,
  input  logic [PR_QSEL_W-1:0] rdQueue,
  output qMask_t               openQ,
  output qMask_t               errVec,
  output qMask_t               readyVec,
  output logic                 rdReady
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pktCnt [PR_QUEUES];

  for (genvar q = 0; q < PR_QUEUES; q++) begin : g_queue
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pktCnt[q] <= '0;
      end else if (strobes.clrQ[q]) begin
        pktCnt[q] <= '0;
      end else if (strobes.incQ[q] && pktCnt[q] != CNT_MAX) begin
        pktCnt[q] <= pktCnt[q] + 1'b1;
      end else if (strobes.decQ[q] && pktCnt[q] != '0) begin
        pktCnt[q] <= pktCnt[q] - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ[q] <= 1'b0;
      end else if (strobes.clrQ[q] || strobes.openClrQ[q]) begin
        openQ[q] <= 1'b0;
      end else if (strobes.openSetQ[q]) begin
        openQ[q] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errVec[q] <= 1'b0;
      end else if (strobes.errSetQ[q]) begin
        errVec[q] <= 1'b1;
      end
    end

    assign readyVec[q] = strobes.active & (pktCnt[q] != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReady <= 1'b0;
    end else begin
      rdReady <= readyVec[rdQueue];
    end
  end
endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker
  import pkt_ready_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrBusWide,
  input  logic                 rdBusWide,
  input  logic                 wrEn,
  input  logic [PR_QSEL_W-1:0] wrQueue,
  input  logic                 wrStart,
  input  logic                 wrEnd,
  input  logic                 rdEn,
  input  logic [PR_QSEL_W-1:0] rdQueue,
  input  logic                 rdEnd,
  input  logic                 prstEn,
  input  logic [PR_QSEL_W-1:0] prstQueue,
  output logic [PR_QUEUES-1:0] readyVec,
  output logic                 rdReady,
  output logic [PR_QUEUES-1:0] errVec
);
  prStrobes_t strobes;
  qMask_t     openQ;

  pr_ctrl i_ctrl (
    .wrBusWide (wrBusWide),
    .rdBusWide (rdBusWide),
    .wrEn      (wrEn),
    .wrQueue   (wrQueue),
    .wrStart   (wrStart),
    .wrEnd     (wrEnd),
    .rdEn      (rdEn),
    .rdQueue   (rdQueue),
    .rdEnd     (rdEnd),
    .prstEn    (prstEn),
    .prstQueue (prstQueue),
    .openQ     (openQ),
    .strobes   (strobes)
  );

  pr_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdQueue  (rdQueue),
    .openQ    (openQ),
    .errVec   (errVec),
    .readyVec (readyVec),
    .rdReady  (rdReady)
  );
endmodule

// File: rtl/pkt_ready_tracker_chk.sv
module pkt_ready_tracker_chk
  import pkt_ready_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrBusWide,
  input logic                 rdBusWide,
  input logic                 wrEn,
  input logic [PR_QSEL_W-1:0] wrQueue,
  input logic                 wrEnd,
  input logic                 rdEn,
  input logic [PR_QSEL_W-1:0] rdQueue,
  input logic                 rdEnd,
  input logic                 prstEn,
  input logic [PR_QSEL_W-1:0] prstQueue,
  input logic [PR_QUEUES-1:0] readyVec,
  input logic                 rdReady,
  input logic [PR_QUEUES-1:0] errVec
);
  logic wideNow;
  assign wideNow = wrBusWide & rdBusWide;

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |-> (readyVec == '0 && errVec == '0 && !rdReady)); // R1

  AST_END_WRITE_READY: assert property (@(posedge clk) disable iff (!rstN)
    (wideNow && wrEn && wrEnd && !(rdEn && rdEnd && rdQueue == wrQueue) && !(prstEn && prstQueue == wrQueue))
    |=> (!wideNow || readyVec[$past(wrQueue)])); // R2

  AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wideNow && wrEn && wrEnd && rdEn && rdEnd && rdQueue == wrQueue && !(prstEn && prstQueue == wrQueue))
    |=> (!wideNow || readyVec[$past(wrQueue)] == $past(readyVec[wrQueue]))); // R4

  AST_RDY_LAGS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> rdReady == $past(readyVec[rdQueue])); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (errVec & $past(errVec)) == $past(errVec)); // R7

  AST_PRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    prstEn |=> !readyVec[$past(prstQueue)]); // R8

  AST_NARROW_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !wideNow |=> !rdReady); // R9
endmodule

bind pkt_ready_tracker pkt_ready_tracker_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrBusWide (wrBusWide),
  .rdBusWide (rdBusWide),
  .wrEn      (wrEn),
  .wrQueue   (wrQueue),
  .wrEnd     (wrEnd),
  .rdEn      (rdEn),
  .rdQueue   (rdQueue),
  .rdEnd     (rdEnd),
  .prstEn    (prstEn),
  .prstQueue (prstQueue),
  .readyVec  (readyVec),
  .rdReady   (rdReady),
  .errVec    (errVec)
);

// File: tb/test_pkt_ready_tracker.sv
`timescale 1ns/1ps
module test_pkt_ready_tracker;
  localparam int NQ    = pkt_ready_pkg::PR_QUEUES;
  localparam int QW    = pkt_ready_pkg::PR_QSEL_W;
  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrBusWide = 1'b1, rdBusWide = 1'b1;
  logic wrEn = 1'b0, wrStart = 1'b0, wrEnd = 1'b0;
  logic rdEn = 1'b0, rdEnd = 1'b0, prstEn = 1'b0;
  logic [QW-1:0] wrQueue = '0, rdQueue = '0, prstQueue = '0;
  logic [NQ-1:0] readyVec, errVec;
  logic rdReady;

  int expCnt [NQ];
  bit expOpen [NQ];
  bit expErr [NQ];
  bit expRdy;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  pkt_ready_tracker #(.CNT_W(CNT_W)) i_pkt_ready_tracker (
    .clk(clk), .rstN(rstN), .wrBusWide(wrBusWide), .rdBusWide(rdBusWide),
    .wrEn(wrEn), .wrQueue(wrQueue), .wrStart(wrStart), .wrEnd(wrEnd),
    .rdEn(rdEn), .rdQueue(rdQueue), .rdEnd(rdEnd),
    .prstEn(prstEn), .prstQueue(prstQueue),
    .readyVec(readyVec), .rdReady(rdReady), .errVec(errVec)
  );

  function automatic logic [NQ-1:0] modelReady(bit act);
    logic [NQ-1:0] r;
    for (int q = 0; q < NQ; q++) r[q] = act && (expCnt[q] != 0);
    return r;
  endfunction

  function automatic logic [NQ-1:0] modelErr();
    logic [NQ-1:0] r;
    for (int q = 0; q < NQ; q++) r[q] = expErr[q];
    return r;
  endfunction

  task automatic compare(string tag);
    logic [NQ-1:0] er;
    er = modelReady(wrBusWide && rdBusWide);
    nChecks += 3;
    if (readyVec !== er) begin
      nFails++;
      $display("FAIL %s readyVec: actual %b expected %b", tag, readyVec, er);
    end
    if (errVec !== modelErr()) begin
      nFails++;
      $display("FAIL %s errVec: actual %b expected %b", tag, errVec, modelErr());
    end
    if (rdReady !== expRdy) begin
      nFails++;
      $display("FAIL %s rdReady: actual %b expected %b", tag, rdReady, expRdy);
    end
  endtask

  // one clock: inputs already set; model at posedge, compare at negedge
  task automatic tick(string tag);
    bit act;
    @(posedge clk);
    act = wrBusWide && rdBusWide;
    expRdy = act && (expCnt[rdQueue] != 0);
    for (int q = 0; q < NQ; q++) begin
      bit wh, rh, wc, rc;
      wh = act && wrEn && (wrQueue == QW'(q));
      rh = act && rdEn && (rdQueue == QW'(q));
      wc = wh && wrEnd;
      rc = rh && rdEnd;
      if (prstEn && prstQueue == QW'(q)) begin
        expCnt[q] = 0;
        expOpen[q] = 0;
      end else begin
        if (wc && !rc && expCnt[q] < CMAX) expCnt[q]++;
        else if (rc && !wc && expCnt[q] > 0) expCnt[q]--;
        if (wh && wrStart && expOpen[q]) expErr[q] = 1;
        if (wc) expOpen[q] = 0;
        else if (wh && wrStart) expOpen[q] = 1;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    wrEn = 0; wrStart = 0; wrEnd = 0; rdEn = 0; rdEnd = 0; prstEn = 0;
  endtask

  task automatic doWrite(int q, bit s, bit e);
    wrEn = 1; wrQueue = QW'(q); wrStart = s; wrEnd = e;
  endtask

  task automatic doRead(int q, bit e);
    rdEn = 1; rdQueue = QW'(q); rdEnd = e;
  endtask

  task automatic resetModel();
    for (int q = 0; q < NQ; q++) begin
      expCnt[q] = 0; expOpen[q] = 0; expErr[q] = 0;
    end
    expRdy = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    resetModel();
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;

    // R2 + R7: single-word packet on queue 3, no open state left
    idle(); doWrite(3, 1, 1); tick("R2");
    idle(); doWrite(3, 1, 0); tick("R7");
    idle(); doWrite(3, 0, 1); tick("R2");
    // R6: rdReady follows one edge later
    idle(); rdQueue = 3; tick("R6");
    idle(); rdQueue = 0; tick("R6");
    // R4: same queue close on both sides
    idle(); doWrite(3, 1, 1); doRead(3, 1); tick("R4");
    // R3: drain queue 3 then an extra close on empty
    idle(); doRead(3, 1); tick("R3");
    idle(); doRead(3, 1); tick("R3");
    idle(); doRead(3, 1); tick("R3");
    // R5: different queues in one cycle
    idle(); doWrite(1, 1, 1); tick("R5");
    idle(); doWrite(2, 1, 1); doRead(1, 1); tick("R5");
    idle(); doWrite(1, 1, 1); doRead(2, 1); tick("R5");
    // R7: start while open sets sticky error
    idle(); doWrite(5, 1, 0); tick("R7");
    idle(); doWrite(5, 1, 0); tick("R7");
    idle(); doWrite(5, 0, 1); tick("R7");
    idle(); tick("R7");
    // R8: partial reset wins over write, keeps error, clears open
    idle(); doWrite(5, 0, 1); tick("R8");
    idle(); doWrite(5, 0, 1); prstEn = 1; prstQueue = 5; tick("R8");
    idle(); doWrite(6, 1, 0); tick("R8");
    idle(); prstEn = 1; prstQueue = 6; tick("R8");
    idle(); doWrite(6, 1, 0); tick("R8");
    // R9: narrow port configuration
    idle(); wrBusWide = 0; doWrite(0, 1, 1); rdQueue = 1; tick("R9");
    idle(); rdBusWide = 0; wrBusWide = 1; doRead(1, 1); tick("R9");
    idle(); rdBusWide = 1; rdQueue = 1; tick("R9");
    idle(); tick("R9");
    // R10: saturation of queue 7
    for (int i = 0; i < 70; i++) begin
      idle(); doWrite(7, 1, 1); tick("R10");
    end
    for (int i = 0; i < CMAX; i++) begin
      idle(); doRead(7, 1); tick("R10");
    end
    idle(); tick("R10");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      wrBusWide = ($urandom_range(0, 19) != 0);
      rdBusWide = ($urandom_range(0, 19) != 0);
      wrEn = $urandom_range(0, 1);
      wrQueue = QW'($urandom_range(0, NQ - 1));
      wrStart = ($urandom_range(0, 3) == 0);
      wrEnd = ($urandom_range(0, 2) == 0);
      rdEn = $urandom_range(0, 1);
      rdQueue = QW'($urandom_range(0, NQ - 1));
      rdEnd = ($urandom_range(0, 2) == 0);
      prstEn = ($urandom_range(0, 39) == 0);
      prstQueue = QW'($urandom_range(0, NQ - 1));
      tick("R5");
    end

    // master reset clears sticky errors
    idle(); wrBusWide = 1; rdBusWide = 1;
    rstN = 1'b0; resetModel();
    @(negedge clk); compare("R1");
    rstN = 1'b1;
    idle(); tick("R1");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule